// File: doc/BRIEF.md
# Bidirectional latchable registered bus transceiver

This block moves data between two parallel buses, side A and side B, through two independent paths. Each path has its own storage element, latch enable, capture clock and output enable. With the latch enable high a path is transparent: the output takes the input combinationally, and the storage element reloads on every system clock. With the latch enable low the storage element loads only on a rising edge of the path's capture clock, and holds otherwise.

The capture clocks are plain inputs that the system clock samples. A rising edge is seen when a sample is 1 and the sample one cycle earlier was 0. Tri-state pins are not modelled. Each side instead has a data output and an output-enable flag. The A-to-B enable is active high and the B-to-A enable is active low. The enables only gate driving: storage keeps working while a side is not driven.

Top module: `bus_xcvr_top`

## Requirements
- R1: Each direction carries WIDTH bits (default 18), and every bit of a direction obeys the same controls. All-ones and alternating patterns pass unchanged.
- R2: While a path's latch enable is 1, its data output equals its data input in the same cycle, with no clock lag.
- R3: While the latch enable is 0, a capture input sampled 1 at a clock edge after being sampled 0 at the previous edge loads the data input present at that edge. The output shows the loaded value from that edge on.
- R4: While the latch enable is 0 and no capture rise is seen, the stored value and the data output stay unchanged, whether the capture input rests high or low.
- R5: When the latch enable falls, the output keeps the input value sampled at the last edge at which the enable was 1. It holds that value until the next capture rise, both when the capture input was high at the fall and when it was low.
- R6: The B-side output enable equals the A-to-B enable input (active high: 1 means drive).
- R7: The A-side output enable is 1 exactly when the B-to-A enable input is 0 (active low).
- R8: Loading and holding are the same whether the output enable is asserted or not. A value captured while a side is undriven appears once the side is enabled.
- R9: During and after reset both stored values are zero. With the latch enables low, both data outputs read zero until a capture.
- R10: The two directions are independent. Activity on one path's controls or data never changes the other path's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | WIDTH | Side A data in (source for A-to-B) |
| b_i | input | WIDTH | Side B data in (source for B-to-A) |
| ab_oe_i | input | 1 | A-to-B output enable, active high |
| ab_le_i | input | 1 | A-to-B latch enable (1 = transparent) |
| ab_cap_i | input | 1 | A-to-B capture clock, sampled |
| ba_oe_ni | input | 1 | B-to-A output enable, active low |
| ba_le_i | input | 1 | B-to-A latch enable (1 = transparent) |
| ba_cap_i | input | 1 | B-to-A capture clock, sampled |
| b_o | output | WIDTH | Side B data out |
| b_oe_o | output | 1 | Side B drive enable |
| a_o | output | WIDTH | Side A data out |
| a_oe_o | output | 1 | Side A drive enable |

## Verification
A corrupted stored value or capture-edge flag stays hidden while a path is transparent. It shows on the output in the first cycle after the latch enable falls. The bench therefore drops the enable with the capture input both high and low, and checks the output in that cycle and in the held cycles that follow. A wrong edge-history bit shows one cycle after a capture rise, as a missed or duplicated load. For that reason the capture input is held high over several cycles and data changes during the hold. Enable polarity errors show in the same cycle as the enable changes.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    MODE_PASS    = 2'd0,
    MODE_CAPTURE = 2'd1,
    MODE_HOLD    = 2'd2
  } xcvr_mode_e;

  function automatic xcvr_mode_e pick_mode(input logic le, input logic rise);
    if (le)        return MODE_PASS;
    else if (rise) return MODE_CAPTURE;
    else           return MODE_HOLD;
  endfunction
endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;

  // R3: a rise is a single-cycle event
  p_one_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH         = 18,
  parameter bit          OE_ACTIVE_LOW = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din_i,
  input  logic             le_i,
  input  logic             cap_i,
  input  logic             oe_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             oe_o
);
  logic             cap_rise;
  logic [WIDTH-1:0] store_q;
  xcvr_mode_e       mode;

  xcvr_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (cap_i),
    .rise_o (cap_rise)
  );

  assign mode = pick_mode(le_i, cap_rise);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_q <= '0;
    end else begin
      unique case (mode)
        MODE_PASS, MODE_CAPTURE: store_q <= din_i;
        default:                 store_q <= store_q;
      endcase
    end
  end

  // transparent bypass avoids a cycle of lag
  assign dout_o = (mode == MODE_PASS) ? din_i : store_q;

  generate
    if (OE_ACTIVE_LOW) begin : g_oe_low
      assign oe_o = ~oe_i;
    end else begin : g_oe_high
      assign oe_o = oe_i;
    end
  endgenerate

  p_pass_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i |=> store_q == $past(din_i));

  p_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && cap_rise) |=> store_q == $past(din_i));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !cap_rise) |=> $stable(store_q));
endmodule

// File: rtl/bus_xcvr_top.sv
module bus_xcvr_top #(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             ab_oe_i,
  input  logic             ab_le_i,
  input  logic             ab_cap_i,
  input  logic             ba_oe_ni,
  input  logic             ba_le_i,
  input  logic             ba_cap_i,
  output logic [WIDTH-1:0] b_o,
  output logic             b_oe_o,
  output logic [WIDTH-1:0] a_o,
  output logic             a_oe_o
);
  xcvr_path #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b0)) u_ab (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  (a_i),
    .le_i   (ab_le_i),
    .cap_i  (ab_cap_i),
    .oe_i   (ab_oe_i),
    .dout_o (b_o),
    .oe_o   (b_oe_o)
  );

  xcvr_path #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b1)) u_ba (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  (b_i),
    .le_i   (ba_le_i),
    .cap_i  (ba_cap_i),
    .oe_i   (ba_oe_ni),
    .dout_o (a_o),
    .oe_o   (a_oe_o)
  );

  // R10: quiet B-to-A controls keep side A steady whatever A-to-B does
  p_indep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ba_le_i && !ba_cap_i) |=> (ba_le_i || $stable(a_o)));
endmodule

// File: tb/bus_xcvr_top_tb.sv
`timescale 1ns/1ps
module bus_xcvr_top_tb;
  localparam int W = 18;
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic ab_oe_i = 1'b0, ab_le_i = 1'b0, ab_cap_i = 1'b0;
  logic ba_oe_ni = 1'b1, ba_le_i = 1'b0, ba_cap_i = 1'b0;
  logic [W-1:0] b_o, a_o;
  logic b_oe_o, a_oe_o;

  always #4 clk = ~clk;

  bus_xcvr_top #(.WIDTH(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i),
    .ab_oe_i(ab_oe_i), .ab_le_i(ab_le_i), .ab_cap_i(ab_cap_i),
    .ba_oe_ni(ba_oe_ni), .ba_le_i(ba_le_i), .ba_cap_i(ba_cap_i),
    .b_o(b_o), .b_oe_o(b_oe_o), .a_o(a_o), .a_oe_o(a_oe_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model state
  logic [W-1:0] m_ab_st = '0, m_ba_st = '0;
  logic m_ab_cq = 1'b0, m_ba_cq = 1'b0;

  // scoreboard queues
  logic [W-1:0] q_b[$], q_a[$];
  logic q_boe[$], q_aoe[$];
  string q_tag[$];
  event item_ev;

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic aoe, input logic ale,
                       input logic acap, input logic [W-1:0] b, input logic boen,
                       input logic ble, input logic bcap, input string tag);
    logic ab_rise, ba_rise;
    @(negedge clk);
    a_i = a; ab_oe_i = aoe; ab_le_i = ale; ab_cap_i = acap;
    b_i = b; ba_oe_ni = boen; ba_le_i = ble; ba_cap_i = bcap;
    #1;
    q_b.push_back(ale ? a : m_ab_st);
    q_boe.push_back(aoe);
    q_a.push_back(ble ? b : m_ba_st);
    q_aoe.push_back(!boen);
    q_tag.push_back(tag);
    -> item_ev;
    @(posedge clk);
    if (rst_ni) begin
      ab_rise = acap && !m_ab_cq;
      ba_rise = bcap && !m_ba_cq;
      if (ale || ab_rise) m_ab_st = a;
      if (ble || ba_rise) m_ba_st = b;
      m_ab_cq = acap;
      m_ba_cq = bcap;
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(item_ev);
      while (q_tag.size() > 0) begin
        logic [W-1:0] eb, ea;
        logic eboe, eaoe;
        string t;
        eb = q_b.pop_front(); eboe = q_boe.pop_front();
        ea = q_a.pop_front(); eaoe = q_aoe.pop_front();
        t = q_tag.pop_front();
        n_cmp += 4;
        if (b_o !== eb) begin
          n_bad++; $display("FAIL %s b_o actual %h expected %h", t, b_o, eb);
        end
        if (b_oe_o !== eboe) begin
          n_bad++; $display("FAIL %s b_oe_o actual %b expected %b", t, b_oe_o, eboe);
        end
        if (a_o !== ea) begin
          n_bad++; $display("FAIL %s a_o actual %h expected %h", t, a_o, ea);
        end
        if (a_oe_o !== eaoe) begin
          n_bad++; $display("FAIL %s a_oe_o actual %b expected %b", t, a_oe_o, eaoe);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R9: reset state, stimulus ignored while in reset
    drive(18'h3FFFF, 0, 0, 1, 18'h15555, 1, 0, 1, "R9");
    drive(18'h12345, 0, 0, 0, 18'h0ABCD, 1, 0, 0, "R9");
    @(negedge clk); rst_ni = 1'b1;
    drive(18'h00000, 0, 0, 0, 18'h00000, 1, 0, 0, "R9");
    // R6 / R7: enable polarity
    drive(18'h00001, 1, 0, 0, 18'h00002, 1, 0, 0, "R6");
    drive(18'h00001, 0, 0, 0, 18'h00002, 0, 0, 0, "R7");
    drive(18'h00001, 1, 0, 0, 18'h00002, 0, 0, 0, "R6_R7");
    // R2 / R1: transparent, several patterns
    drive(18'h2A5A5, 1, 1, 0, 18'h15A5A, 0, 1, 0, "R2");
    drive(ONES,      1, 1, 0, 18'h00000, 0, 1, 0, "R1");
    drive(18'h2AAAA, 1, 1, 0, 18'h15555, 0, 1, 0, "R1");
    drive(18'h00F0F, 1, 1, 1, 18'h3C3C3, 0, 1, 1, "R2");
    // R5: enable falls while capture high; data changes, held value stays
    drive(18'h11111, 1, 1, 1, 18'h22222, 0, 1, 1, "R2");
    drive(18'h33333, 1, 0, 1, 18'h04444, 0, 0, 1, "R5");
    drive(18'h05555, 1, 0, 1, 18'h06666, 0, 0, 1, "R4");
    drive(18'h07777, 1, 0, 0, 18'h08888, 0, 0, 0, "R4");
    // R3: capture rise loads
    drive(18'h09999, 1, 0, 1, 18'h0AAAA, 0, 0, 1, "R3");
    drive(18'h0BBBB, 1, 0, 1, 18'h0CCCC, 0, 0, 1, "R3");
    drive(18'h0DDDD, 1, 0, 1, 18'h0EEEE, 0, 0, 1, "R4");
    drive(18'h0DDDD, 1, 0, 0, 18'h0EEEE, 0, 0, 0, "R4");
    // R5: enable falls while capture low, then rise
    drive(18'h1F00F, 1, 1, 0, 18'h2F0F0, 0, 1, 0, "R2");
    drive(18'h30303, 1, 0, 0, 18'h0C0C0, 0, 0, 0, "R5");
    drive(18'h31313, 1, 0, 0, 18'h0D0D0, 0, 0, 0, "R5");
    drive(18'h32323, 1, 0, 1, 18'h0E0E0, 0, 0, 1, "R5_R3");
    drive(18'h34343, 1, 0, 1, 18'h0F0F0, 0, 0, 1, "R4");
    // R8: capture while undriven, then enable
    drive(18'h00000, 0, 0, 0, 18'h00000, 1, 0, 0, "R8");
    drive(18'h2BEEF, 0, 0, 1, 18'h1CAFE, 1, 0, 1, "R8");
    drive(18'h00000, 0, 0, 1, 18'h00000, 1, 0, 1, "R8");
    drive(18'h00000, 1, 0, 0, 18'h00000, 0, 0, 0, "R8");
    drive(18'h3AAAA, 0, 1, 0, 18'h05555, 1, 1, 0, "R8");
    drive(18'h00000, 1, 0, 0, 18'h00000, 0, 0, 0, "R8");
    // R10: one path busy, other quiet
    drive(18'h12121, 1, 1, 0, 18'h3FFFF, 0, 0, 0, "R10");
    drive(18'h21212, 1, 0, 1, 18'h2EEEE, 0, 0, 0, "R10");
    drive(18'h0F0F0, 1, 0, 0, 18'h1DDDD, 0, 1, 0, "R10");
    drive(18'h30F0F, 1, 0, 0, 18'h1CCCC, 0, 0, 1, "R10");
    // mixed stimulus over all modes
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] ra, rb;
      logic [7:0] c;
      ra = W'($urandom); rb = W'($urandom); c = 8'($urandom);
      drive(ra, c[0], c[1] & c[2], c[3], rb, c[4], c[5] & c[6], c[7], "R10_mix");
    end
    @(negedge clk);
    summary();
  end
endmodule